// File: doc/BRIEF.md
# Wear-Leveling Block Allocator

This block decides which physical block of a non-volatile array takes each new piece of data, so that erase/write wear spreads evenly across the array. It keeps three items of bookkeeping per block in volatile flops: a wear counter, an "in use" bit and a "worn out" bit. The memory bus, the data movement and saving this state across power loss all belong to the surrounding system. The block only makes decisions and keeps its records.

A controller sends three kinds of request, one per cycle: take a block, release a block, and report a finished write to a block together with a health result. The health result says whether the array corrected a bit error on that write. The block answers a take request with a block index, or with a "no space" pulse when nothing is left. Whenever the wear gap between data in use and the freshest free block grows too wide, it raises a relocation request that names a source and a destination. Blocks are retired for good when their counter reaches the endurance limit or when a write reports a corrected error.

The default build has eight blocks for four data sources, which is twice the capacity the sources need. The spare blocks give the leveling room to work.

Top module: `wl_alloc`

## Requirements
- R1: A write-done report for block i raises the wear counter of block i by exactly one. No other counter changes.
- R2: A take request is answered one cycle later with `gnt_vld` high for one cycle. `gnt_idx` names the free, live block with the smallest counter, taking the lowest index on a tie. That block's bit in `alloc_map` is then 1.
- R3: `reloc_req` is 1 exactly when both of these hold: some in-use live block exists, and some free live block exists. The largest in-use counter must also exceed the smallest free counter by more than `SPREAD_MAX`. `reloc_src` is the in-use live block with the largest counter and `reloc_dst` is the free live block with the smallest counter; both take the lowest index on ties.
- R4: A block whose counter reaches `ENDURANCE` on a write has its bit in `retired_map` set. A retired bit never clears until reset, and a retired block is never granted or named for relocation.
- R5: A write-done report with `wr_flag` = 1 retires that block in the same update, whatever its counter.
- R6: A take request that finds no free live block gives a one-cycle `no_space` pulse with `gnt_vld` low, and no bookkeeping changes.
- R7: A release request clears the block's bit in `alloc_map` and leaves its counter as it was.
- R8: Counters saturate at 2^CNT_W-1 and never wrap.
- R9: After reset all counters are zero, `alloc_map` and `retired_map` are zero, and `gnt_vld`, `no_space` and `reloc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Take a block |
| free_req | input | 1 | Release block `free_idx` |
| free_idx | input | IDX_W | Block to release |
| wr_done | input | 1 | A write to block `wr_idx` has finished |
| wr_idx | input | IDX_W | Block that was written |
| wr_flag | input | 1 | The write reported a corrected bit error |
| gnt_vld | output | 1 | One-cycle pulse: `gnt_idx` is granted |
| gnt_idx | output | IDX_W | Granted block |
| no_space | output | 1 | One-cycle pulse: a take request could not be met |
| reloc_req | output | 1 | Wear gap too wide, relocation advised |
| reloc_src | output | IDX_W | Most-worn in-use block |
| reloc_dst | output | IDX_W | Least-worn free block |
| alloc_map | output | NUM_BLK | In-use bit per block |
| retired_map | output | NUM_BLK | Worn-out bit per block |

## Verification
The assertions take for granted that at most one of `alloc_req`, `free_req` and `wr_done` is high in any cycle. They also assume that `free_idx` and `wr_idx` stay below `NUM_BLK`. Without these conditions a grant and a retirement of the same block could coincide, and a same-cycle release could mask a grant. The bench keeps within these conditions by issuing every operation alone, with an idle cycle after it. It draws block indices modulo the block count. A checked-in model of the counters and maps predicts every grant, map and relocation output.

// File: rtl/wl_pkg.sv
// wl_pkg: shared helpers for the wear-leveling allocator.
// Assumes callers pass counts already widened to 32 bits.
package wl_pkg;

    // True when hi exceeds lo by more than gap.
    function automatic logic exceeds(input int unsigned hi, input int unsigned lo,
                                     input int unsigned gap);
        return hi > lo + gap;
    endfunction

    // True when a wear count has reached a limit.
    function automatic logic reaches(input int unsigned cnt, input int unsigned lim);
        return cnt >= lim;
    endfunction

endpackage

// File: rtl/wl_slot.sv
// wl_slot: bookkeeping for one physical block. It holds a saturating wear
// counter, an in-use bit and a sticky worn-out bit.
// Assumes set_alloc and clr_alloc are never both high.
module wl_slot
    import wl_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned ENDURANCE = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_alloc,
    input  logic             clr_alloc,
    input  logic             wr_hit,
    input  logic             wr_flag,
    output logic             alloc,
    output logic             retired,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_nxt;

    // Next count after a write, held at the top value.
    assign cnt_nxt = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;

    // Update counter, in-use bit and worn-out bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            alloc   <= 1'b0;
            retired <= 1'b0;
        end else begin
            if (wr_hit) cnt <= cnt_nxt;
            if (set_alloc)      alloc <= 1'b1;
            else if (clr_alloc) alloc <= 1'b0;
            if (wr_hit && (wr_flag || reaches(32'(cnt_nxt), ENDURANCE)))
                retired <= 1'b1;
        end
    end
endmodule

// File: rtl/wl_pick.sv
// wl_pick: scans masked counters and returns the smallest one (BIGGEST=0)
// or the largest one (BIGGEST=1). The lowest index wins a tie.
// Assumes IDX_W can hold N-1.
module wl_pick #(
    parameter int unsigned N       = 8,
    parameter int unsigned W       = 8,
    parameter int unsigned IDX_W   = 3,
    parameter bit          BIGGEST = 1'b0
) (
    input  logic [N-1:0][W-1:0] val,
    input  logic [N-1:0]        mask,
    output logic                found,
    output logic [IDX_W-1:0]    idx,
    output logic [W-1:0]        best
);
    logic [N-1:0] better;

    // Per-entry comparison against the running best, variant chosen by BIGGEST.
    generate
        if (BIGGEST) begin : g_max
            // Scan for the largest masked value.
            always_comb begin
                found = 1'b0;
                idx   = '0;
                best  = '0;
                better = '0;
                for (int i = 0; i < int'(N); i++) begin
                    better[i] = mask[i] && (!found || val[i] > best);
                    if (better[i]) begin
                        found = 1'b1;
                        idx   = IDX_W'(i);
                        best  = val[i];
                    end
                end
            end
        end else begin : g_min
            // Scan for the smallest masked value.
            always_comb begin
                found = 1'b0;
                idx   = '0;
                best  = '0;
                better = '0;
                for (int i = 0; i < int'(N); i++) begin
                    better[i] = mask[i] && (!found || val[i] < best);
                    if (better[i]) begin
                        found = 1'b1;
                        idx   = IDX_W'(i);
                        best  = val[i];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wl_alloc.sv
// wl_alloc: wear-leveling block allocator. It grants the least-worn free live
// block, retires blocks on the endurance limit or a health flag, and advises
// relocation when the wear gap grows too wide.
// Assumes at most one request per cycle and in-range indices.
module wl_alloc
    import wl_pkg::*;
#(
    parameter int unsigned NUM_BLK    = 8,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned ENDURANCE  = 200,
    parameter int unsigned SPREAD_MAX = 64,
    localparam int unsigned IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic               free_req,
    input  logic [IDX_W-1:0]   free_idx,
    input  logic               wr_done,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_flag,
    output logic               gnt_vld,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               no_space,
    output logic               reloc_req,
    output logic [IDX_W-1:0]   reloc_src,
    output logic [IDX_W-1:0]   reloc_dst,
    output logic [NUM_BLK-1:0] alloc_map,
    output logic [NUM_BLK-1:0] retired_map
);
    logic [NUM_BLK-1:0][CNT_W-1:0] cnt;
    logic [NUM_BLK-1:0] set_alloc, clr_alloc, wr_hit;
    logic [NUM_BLK-1:0] eligible, holding;
    logic               dst_found, src_found;
    logic [IDX_W-1:0]   dst_idx, src_idx;
    logic [CNT_W-1:0]   dst_val, src_val;

    // Decode requests into per-block strobes.
    always_comb begin
        set_alloc = '0;
        clr_alloc = '0;
        wr_hit    = '0;
        if (alloc_req && dst_found) set_alloc[dst_idx] = 1'b1;
        if (free_req)               clr_alloc[free_idx] = 1'b1;
        if (wr_done)                wr_hit[wr_idx] = 1'b1;
    end

    generate
        for (genvar g = 0; g < int'(NUM_BLK); g++) begin : g_slot
            wl_slot #(
                .CNT_W     (CNT_W),
                .ENDURANCE (ENDURANCE)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_alloc (set_alloc[g]),
                .clr_alloc (clr_alloc[g]),
                .wr_hit    (wr_hit[g]),
                .wr_flag   (wr_flag),
                .alloc     (alloc_map[g]),
                .retired   (retired_map[g]),
                .cnt       (cnt[g])
            );
        end
    endgenerate

    // Live blocks split into free candidates and in-use holders.
    assign eligible = ~alloc_map & ~retired_map;
    assign holding  =  alloc_map & ~retired_map;

    wl_pick #(.N(NUM_BLK), .W(CNT_W), .IDX_W(IDX_W), .BIGGEST(1'b0)) u_least (
        .val(cnt), .mask(eligible), .found(dst_found), .idx(dst_idx), .best(dst_val)
    );

    wl_pick #(.N(NUM_BLK), .W(CNT_W), .IDX_W(IDX_W), .BIGGEST(1'b1)) u_most (
        .val(cnt), .mask(holding), .found(src_found), .idx(src_idx), .best(src_val)
    );

    // Relocation advice straight from the current bookkeeping.
    assign reloc_req = src_found && dst_found &&
                       exceeds(32'(src_val), 32'(dst_val), SPREAD_MAX);
    assign reloc_src = src_idx;
    assign reloc_dst = dst_idx;

    // Register the answer to a take request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_vld  <= 1'b0;
            gnt_idx  <= '0;
            no_space <= 1'b0;
        end else begin
            gnt_vld  <= alloc_req && dst_found;
            no_space <= alloc_req && !dst_found;
            if (alloc_req && dst_found) gnt_idx <= dst_idx;
        end
    end
endmodule

// File: rtl/wl_alloc_chk.sv
// wl_alloc_chk: property checker for wl_alloc, attached by bind.
// Assumes one request per cycle and in-range indices.
module wl_alloc_chk #(
    parameter int unsigned NUM_BLK = 8,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          free_req,
    input logic [IDX_W-1:0]              free_idx,
    input logic                          wr_done,
    input logic [IDX_W-1:0]              wr_idx,
    input logic                          wr_flag,
    input logic                          gnt_vld,
    input logic [IDX_W-1:0]              gnt_idx,
    input logic                          no_space,
    input logic                          reloc_req,
    input logic [IDX_W-1:0]              reloc_src,
    input logic [IDX_W-1:0]              reloc_dst,
    input logic [NUM_BLK-1:0]            alloc_map,
    input logic [NUM_BLK-1:0]            retired_map,
    input logic [NUM_BLK-1:0][CNT_W-1:0] cnt
);
    logic             p_vld, p_flag;
    logic [IDX_W-1:0] p_idx;
    logic [CNT_W-1:0] p_val;

    // Remember the last write report and the count it started from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_vld  <= 1'b0;
            p_flag <= 1'b0;
            p_idx  <= '0;
            p_val  <= '0;
        end else begin
            p_vld  <= wr_done;
            p_flag <= wr_flag;
            p_idx  <= wr_idx;
            p_val  <= cnt[wr_idx];
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (p_vld && !(&p_val)) |-> cnt[p_idx] == p_val + 1'b1); // R1

    AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (p_vld && (&p_val)) |-> (&cnt[p_idx])); // R8

    AST_GNT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (alloc_map[gnt_idx] && !retired_map[gnt_idx])); // R2

    AST_RELOC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_req |-> (alloc_map[reloc_src] && !retired_map[reloc_src] &&
                       !alloc_map[reloc_dst] && !retired_map[reloc_dst])); // R3

    AST_RET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (~retired_map & $past(retired_map)) == '0); // R4

    AST_FLAG_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (p_vld && p_flag) |-> retired_map[p_idx]); // R5

    AST_NOSPACE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        no_space |-> (!gnt_vld && (&(alloc_map | retired_map)))); // R6

    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        free_req |=> !alloc_map[$past(free_idx)]); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!gnt_vld && !no_space && alloc_map == '0 && retired_map == '0)); // R9
endmodule

bind wl_alloc wl_alloc_chk #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .free_req(free_req), .free_idx(free_idx),
    .wr_done(wr_done), .wr_idx(wr_idx), .wr_flag(wr_flag),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .no_space(no_space),
    .reloc_req(reloc_req), .reloc_src(reloc_src), .reloc_dst(reloc_dst),
    .alloc_map(alloc_map), .retired_map(retired_map), .cnt(cnt)
);

// File: tb/wl_alloc_bench.sv
// wl_alloc_bench: directed corner cases plus a long seeded sweep against a
// bench-side model of counters and maps.
module wl_alloc_bench;
    localparam int NB   = 8;
    localparam int CW   = 4;
    localparam int ENDU = 10;
    localparam int GAP  = 4;
    localparam int CTOP = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 0, free_req = 0, wr_done = 0, wr_flag = 0;
    logic [2:0] free_idx = '0, wr_idx = '0;
    logic gnt_vld, no_space, reloc_req;
    logic [2:0] gnt_idx, reloc_src, reloc_dst;
    logic [NB-1:0] alloc_map, retired_map;

    // Second copy with tiny counters to observe saturation.
    logic s_alloc = 0, s_wr = 0;
    logic [1:0] s_widx = '0;
    logic s_gnt, s_nosp, s_reloc;
    logic [1:0] s_gidx, s_src, s_dst;
    logic [3:0] s_amap, s_rmap;

    int checks = 0, errors = 0;
    int m_cnt [NB];
    bit m_alloc [NB];
    bit m_ret [NB];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    wl_alloc #(.NUM_BLK(NB), .CNT_W(CW), .ENDURANCE(ENDU), .SPREAD_MAX(GAP)) u_wl_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .free_req(free_req),
        .free_idx(free_idx), .wr_done(wr_done), .wr_idx(wr_idx), .wr_flag(wr_flag),
        .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .no_space(no_space),
        .reloc_req(reloc_req), .reloc_src(reloc_src), .reloc_dst(reloc_dst),
        .alloc_map(alloc_map), .retired_map(retired_map)
    );

    wl_alloc #(.NUM_BLK(4), .CNT_W(3), .ENDURANCE(8), .SPREAD_MAX(5)) u_wl_alloc_sat (
        .clk(clk), .rst_n(rst_n), .alloc_req(s_alloc), .free_req(1'b0),
        .free_idx(2'd0), .wr_done(s_wr), .wr_idx(s_widx), .wr_flag(1'b0),
        .gnt_vld(s_gnt), .gnt_idx(s_gidx), .no_space(s_nosp),
        .reloc_req(s_reloc), .reloc_src(s_src), .reloc_dst(s_dst),
        .alloc_map(s_amap), .retired_map(s_rmap)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < NB; i++) begin
            m_cnt[i] = 0; m_alloc[i] = 0; m_ret[i] = 0;
        end
    endfunction

    // Least-worn free live block, lowest index first.
    function automatic bit pick_free(output int idx);
        bit f = 0;
        idx = 0;
        for (int i = 0; i < NB; i++)
            if (!m_alloc[i] && !m_ret[i] && (!f || m_cnt[i] < m_cnt[idx])) begin
                f = 1; idx = i;
            end
        return f;
    endfunction

    // Most-worn in-use live block, lowest index first.
    function automatic bit pick_held(output int idx);
        bit f = 0;
        idx = 0;
        for (int i = 0; i < NB; i++)
            if (m_alloc[i] && !m_ret[i] && (!f || m_cnt[i] > m_cnt[idx])) begin
                f = 1; idx = i;
            end
        return f;
    endfunction

    function automatic int map_of(input bit which);
        int v = 0;
        for (int i = 0; i < NB; i++)
            if (which ? m_ret[i] : m_alloc[i]) v |= (1 << i);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One operation, an idle cycle, then compare every output to the model.
    task automatic step(input bit a, input bit f, input int fi,
                        input bit w, input int wi, input bit fl);
        int ei, si, di;
        bit ef, sf, df, er;
        @(negedge clk);
        alloc_req = a; free_req = f; free_idx = 3'(fi);
        wr_done = w; wr_idx = 3'(wi); wr_flag = fl;
        ef = pick_free(ei);
        if (a && ef) m_alloc[ei] = 1;
        if (f) m_alloc[fi] = 0;
        if (w) begin
            if (m_cnt[wi] < CTOP) m_cnt[wi]++;
            if (fl || m_cnt[wi] >= ENDU) m_ret[wi] = 1;
        end
        @(negedge clk);
        alloc_req = 0; free_req = 0; wr_done = 0; wr_flag = 0;
        if (a && ef) begin
            chk(gnt_vld === 1'b1, "R2 grant pulse", int'(gnt_vld), 1);
            chk(int'(gnt_idx) == ei, "R2 grant index", int'(gnt_idx), ei);
            chk(no_space === 1'b0, "R2 no_space low on grant", int'(no_space), 0);
        end else if (a) begin
            chk(no_space === 1'b1, "R6 no_space pulse", int'(no_space), 1);
            chk(gnt_vld === 1'b0, "R6 no grant when full", int'(gnt_vld), 0);
        end else begin
            chk(gnt_vld === 1'b0 && no_space === 1'b0, "R2 quiet without request",
                int'({gnt_vld, no_space}), 0);
        end
        chk(int'(alloc_map) == map_of(0), "R7 in-use map", int'(alloc_map), map_of(0));
        chk(int'(retired_map) == map_of(1), "R4/R5 retired map", int'(retired_map), map_of(1));
        sf = pick_held(si);
        df = pick_free(di);
        er = sf && df && (m_cnt[si] > m_cnt[di] + GAP);
        chk(reloc_req === er, "R1/R3 relocation flag", int'(reloc_req), int'(er));
        if (er) begin
            chk(int'(reloc_src) == si, "R3 relocation source", int'(reloc_src), si);
            chk(int'(reloc_dst) == di, "R3 relocation destination", int'(reloc_dst), di);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: quiet reset state.
        chk(gnt_vld === 0 && no_space === 0 && reloc_req === 0, "R9 outputs after reset",
            int'({gnt_vld, no_space, reloc_req}), 0);
        chk(alloc_map === '0 && retired_map === '0, "R9 maps after reset",
            int'({alloc_map, retired_map}), 0);

        // R2: all counts equal, lowest index wins.
        step(1, 0, 0, 0, 0, 0);
        chk(int'(gnt_idx) == 0, "R2 tie picks index 0", int'(gnt_idx), 0);

        // R1/R3: gap equal to the limit does not trigger; one more does.
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, 0);
        chk(reloc_req === 1'b0, "R3 gap at limit stays low", int'(reloc_req), 0);
        step(0, 0, 0, 1, 0, 0);
        chk(reloc_req === 1'b1 && reloc_src == 0 && reloc_dst == 1,
            "R1 five writes open the gap", int'({reloc_req, reloc_src, reloc_dst}), 'b1_000_001);

        // R7: released block keeps its wear, so a fresher block is chosen.
        step(0, 1, 0, 0, 0, 0);
        chk(alloc_map[0] === 1'b0, "R7 release clears in-use bit", int'(alloc_map[0]), 0);
        step(1, 0, 0, 0, 0, 0);
        chk(int'(gnt_idx) == 1, "R7 counter kept after release", int'(gnt_idx), 1);

        // R5: flagged write retires a nearly fresh block.
        step(0, 0, 0, 1, 3, 1);
        chk(retired_map[3] === 1'b1, "R5 flag retires block 3", int'(retired_map[3]), 1);

        // R6: take everything that is left, then one more.
        for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, 0);
        chk(int'(gnt_idx) == 0, "R2 worn block granted last", int'(gnt_idx), 0);
        step(1, 0, 0, 0, 0, 0);
        chk(no_space === 1'b1, "R6 array full", int'(no_space), 1);

        // R4: block 2 retires exactly on its tenth write.
        for (int k = 0; k < ENDU - 1; k++) step(0, 0, 0, 1, 2, 0);
        chk(retired_map[2] === 1'b0, "R4 not retired below limit", int'(retired_map[2]), 0);
        step(0, 0, 0, 1, 2, 0);
        chk(retired_map[2] === 1'b1, "R4 retired at limit", int'(retired_map[2]), 1);
        step(0, 1, 2, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        chk(no_space === 1'b1, "R4 retired block never granted", int'(no_space), 1);

        // Seeded sweep in several epochs, each from reset.
        for (int ep = 0; ep < 8; ep++) begin
            do_reset();
            for (int n = 0; n < 500; n++) begin
                int kind, bi;
                bit fl;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                kind = int'(lfsr[1:0]) % 3;
                bi   = int'(lfsr[6:4]);
                fl   = (lfsr[11:8] == 4'd0);
                case (kind)
                    0:       step(1, 0, 0, 0, 0, 0);
                    1:       step(0, 1, bi, 0, 0, 0);
                    default: step(0, 0, 0, 1, bi, fl);
                endcase
            end
        end

        // R8: tiny counter saturates at 7 rather than wrapping to 2.
        do_reset();
        @(negedge clk);
        s_alloc = 1'b1;
        @(negedge clk);
        s_alloc = 1'b0;
        chk(s_gnt === 1'b1 && s_gidx == 2'd0, "R8 setup grant", int'(s_gidx), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            s_wr = 1'b1; s_widx = 2'd0;
            @(negedge clk);
            s_wr = 1'b0;
        end
        chk(s_reloc === 1'b1 && s_src == 2'd0 && s_dst == 2'd1, "R8 saturated count",
            int'({s_reloc, s_src, s_dst}), 'b1_00_01);
        chk(s_rmap === 4'd0, "R8 unreachable limit never retires", int'(s_rmap), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule